// File: doc/BRIEF.md
# Per-Pin Edge-Triggered GPIO Interrupt Bank

This block gathers a parameterised bank of general-purpose pins (32 by default) behind a small word-wide register port. Each pin owns an 8-bit configuration byte. That byte chooses whether the pin drives its pad, whether its input is watched, whether it may request an interrupt, and which transition of the input counts as an event: a rising edge, a falling edge or either edge. Software sets the output levels, reads the synchronised input levels and reads all pending flags in one status word.

Every input passes through a two-stage synchroniser. A third flop holds the value from one clock earlier, and an edge is found by comparing the two. Each pin has a two-state pending machine, `PEND_IDLE` and `PEND_HELD`. A qualifying edge takes `PEND_IDLE` to `PEND_HELD` (transition SET). A write of 1 to the pin's status bit takes `PEND_HELD` back to `PEND_IDLE` (transition CLEAR), unless a new edge arrives in the same cycle (transition RESET_BY_EDGE, which stays in `PEND_HELD`). While the machine is in `PEND_HELD` and the pin's interrupt enable is set, the pin's own request line to the interrupt controller stays high.

Register map, with N the pin count: addresses 0 to N-1 hold the configuration bytes, N holds the output levels, N+1 holds the input levels and N+2 holds the pending status.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset all configuration bytes, output levels and pending flags are 0, so `irq`, `pin_oe` and `pin_out` are all low.
- R2: A write to address k (k < N) stores byte `bus_wdata[7:0]` as pin k's configuration and reads back at the same address. Bit 0 is output enable and drives `pin_oe[k]`, bit 1 is input enable, bit 3 is interrupt enable and bits 7:5 are the trigger code. 0x05 gives a plain output and 0x42 gives an input set for rising edges.
- R3: A write to address N sets `pin_out` to `bus_wdata[N-1:0]` from the next clock on, and a read of address N returns that value.
- R4: A read of address N+1 returns the inputs after two synchronising flops: a change at a pin shows up after the second rising clock edge.
- R5: Trigger code 010 sets the pending flag on a 0-to-1 input change and ignores a 1-to-0 change. `irq[k]` rises after the third rising clock edge following the pin change.
- R6: Trigger code 011 sets the pending flag only on a 1-to-0 input change.
- R7: Trigger code 100 sets the pending flag on either input change.
- R8: No pending flag is set when the trigger code is any value other than 010, 011 or 100, when input enable is 0, or when interrupt enable is 0.
- R9: A pending flag and its request stay asserted until software writes 1 to that pin's bit at address N+2. Writing 0 to a bit there has no effect. The status word reads back as bit k = pin k pending.
- R10: If a clear write and a qualifying edge on the same pin fall in the same cycle, the edge wins and the flag stays set.
- R11: `irq[k]` equals pending AND interrupt enable. Clearing the interrupt enable hides a request but keeps the flag, which can still be read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` (combinational) |
| pin_in | input | NPINS | Asynchronous pad inputs |
| pin_out | output | NPINS | Output levels |
| pin_oe | output | NPINS | Per-pin output enable |
| irq | output | NPINS | Per-pin interrupt requests |

## Verification
The trigger logic is exercised with single rising and falling transitions on pins set for each of the three trigger codes. This shows whether each code decodes the right edge direction and whether a wrong-direction change is ignored. Further pins hold a reserved trigger code, lack input enable or lack interrupt enable, which separates the three gating conditions from one another. Sampling the request before and after the third clock edge pins down the latency. A clear written in the exact cycle the edge is detected separates edge-wins from clear-wins, and long idle waits plus writes of 0 to the status word distinguish a sticky flag from a self-clearing one.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int CFG_W = 8;

    localparam logic [2:0] TRIG_RISE = 3'b010;
    localparam logic [2:0] TRIG_FALL = 3'b011;
    localparam logic [2:0] TRIG_BOTH = 3'b100;

    typedef struct packed {
        logic [2:0] trig;
        logic       rsvd4;
        logic       irq_en;
        logic       rsvd2;
        logic       in_en;
        logic       out_en;
    } pin_cfg_t;

    typedef enum logic {
        PEND_IDLE = 1'b0,
        PEND_HELD = 1'b1
    } pend_state_e;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pad_in,
    output logic level_now,
    output logic level_prev
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], pad_in};
        end
    end

    assign level_now  = chain[STAGES-1];
    assign level_prev = chain[STAGES];
endmodule

// File: rtl/gpio_edge_pend.sv
module gpio_edge_pend
    import gpio_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_raw,
    input  logic             level_now,
    input  logic             level_prev,
    input  logic             clr_req,
    output logic             hit,
    output logic             pend,
    output logic             req
);
    pin_cfg_t    cfg;
    pend_state_e state_q, state_d;
    logic        rise, fall, edge_sel;

    assign cfg  = pin_cfg_t'(cfg_raw);
    assign rise = level_now & ~level_prev;
    assign fall = ~level_now & level_prev;

    always_comb begin
        case (cfg.trig)
            TRIG_RISE: edge_sel = rise;
            TRIG_FALL: edge_sel = fall;
            TRIG_BOTH: edge_sel = rise | fall;
            default:   edge_sel = 1'b0;
        endcase
    end

    assign hit = edge_sel & cfg.in_en & cfg.irq_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PEND_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PEND_IDLE: if (hit) state_d = PEND_HELD;
            PEND_HELD: if (clr_req && !hit) state_d = PEND_IDLE;
        endcase
    end

    always_comb begin
        pend = (state_q == PEND_HELD);
        req  = pend & cfg.irq_en;
    end
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int DW    = 32,
    parameter int AW    = $clog2(NPINS + 3)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [AW-1:0]               addr,
    input  logic [DW-1:0]               wdata,
    output logic [NPINS-1:0][CFG_W-1:0] cfg_bytes,
    output logic [NPINS-1:0]            out_level,
    output logic [NPINS-1:0]            clr_mask
);
    localparam logic [AW-1:0] A_OUT  = AW'(NPINS);
    localparam logic [AW-1:0] A_STAT = AW'(NPINS + 2);

    for (genvar k = 0; k < NPINS; k++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_bytes[k] <= '0;
            end else if (we && addr == AW'(k)) begin
                cfg_bytes[k] <= wdata[CFG_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_level <= '0;
        end else if (we && addr == A_OUT) begin
            out_level <= wdata[NPINS-1:0];
        end
    end

    assign clr_mask = (we && addr == A_STAT) ? wdata[NPINS-1:0] : '0;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int DW    = 32,
    parameter int AW    = $clog2(NPINS + 3)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic [NPINS-1:0] irq
);
    localparam logic [AW-1:0] A_OUT  = AW'(NPINS);
    localparam logic [AW-1:0] A_IN   = AW'(NPINS + 1);
    localparam logic [AW-1:0] A_STAT = AW'(NPINS + 2);

    logic [NPINS-1:0][CFG_W-1:0] cfg_bytes;
    logic [NPINS-1:0]            out_level, clr_vec;
    logic [NPINS-1:0]            lvl_now, lvl_prev;
    logic [NPINS-1:0]            hit_vec, pend_vec, ien_vec;

    gpio_cfg_regs #(.NPINS(NPINS), .DW(DW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .cfg_bytes (cfg_bytes),
        .out_level (out_level),
        .clr_mask  (clr_vec)
    );

    for (genvar k = 0; k < NPINS; k++) begin : g_pin
        pin_cfg_t c;
        assign c          = pin_cfg_t'(cfg_bytes[k]);
        assign pin_oe[k]  = c.out_en;
        assign ien_vec[k] = c.irq_en;

        gpio_pin_sync #(.STAGES(2)) u_sync (
            .clk        (clk),
            .rst_n      (rst_n),
            .pad_in     (pin_in[k]),
            .level_now  (lvl_now[k]),
            .level_prev (lvl_prev[k])
        );

        gpio_edge_pend u_pend (
            .clk        (clk),
            .rst_n      (rst_n),
            .cfg_raw    (cfg_bytes[k]),
            .level_now  (lvl_now[k]),
            .level_prev (lvl_prev[k]),
            .clr_req    (clr_vec[k]),
            .hit        (hit_vec[k]),
            .pend       (pend_vec[k]),
            .req        (irq[k])
        );
    end

    assign pin_out = out_level;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_OUT) begin
            bus_rdata[NPINS-1:0] = out_level;
        end else if (bus_addr == A_IN) begin
            bus_rdata[NPINS-1:0] = lvl_now;
        end else if (bus_addr == A_STAT) begin
            bus_rdata[NPINS-1:0] = pend_vec;
        end else begin
            for (int k = 0; k < NPINS; k++) begin
                if (bus_addr == AW'(k)) bus_rdata[CFG_W-1:0] = cfg_bytes[k];
            end
        end
    end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
    parameter int NPINS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic [NPINS-1:0] pin_oe,
    input logic [NPINS-1:0] irq,
    input logic [NPINS-1:0] pend_vec,
    input logic [NPINS-1:0] hit_vec,
    input logic [NPINS-1:0] clr_vec,
    input logic [NPINS-1:0] ien_vec
);
    p_req_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq & ~ien_vec) == '0);

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend_vec) & ~$past(clr_vec)) & ~pend_vec) == '0);

    p_edge_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hit_vec) & ~pend_vec) == '0);

    p_set_needs_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vec & ~$past(pend_vec) & ~$past(hit_vec)) == '0);

    p_oe_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_we) |-> $stable(pin_oe));
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .pin_oe   (pin_oe),
    .irq      (irq),
    .pend_vec (pend_vec),
    .hit_vec  (hit_vec),
    .clr_vec  (clr_vec),
    .ien_vec  (ien_vec)
);

// File: tb/gpio_irq_bank_test.sv
`timescale 1ns/1ps
module gpio_irq_bank_test;
    localparam int N  = 32;
    localparam int DW = 32;
    localparam int AW = $clog2(N + 3);
    localparam int A_OUT = N, A_IN = N + 1, A_STAT = N + 2;
    localparam int K_IRQ = 0, K_RD = 1, K_OUT = 2, K_OE = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out, pin_oe, irq;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 0;

    typedef struct {
        string       req;
        int          kind;
        int          idx;
        logic [31:0] exp;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    gpio_irq_bank #(.NPINS(N), .DW(DW), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            wait (sb.size() > 0);
            #1;
            begin
                item_t it;
                logic [31:0] got;
                it = sb.pop_front();
                case (it.kind)
                    K_IRQ:   got = 32'(irq[it.idx]);
                    K_OE:    got = 32'(pin_oe[it.idx]);
                    K_OUT:   got = 32'(pin_out);
                    default: got = bus_rdata;
                endcase
                n_run++;
                if (got !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: got %h expected %h", it.req, got, it.exp);
                end
            end
        end
    end

    task automatic expect_item(string req, int kind, int idx, logic [31:0] exp);
        item_t it;
        it.req = req; it.kind = kind; it.idx = idx; it.exp = exp;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_expect(string req, int a, logic [31:0] exp);
        @(negedge clk);
        bus_addr = AW'(a);
        expect_item(req, K_RD, 0, exp);
    endtask

    task automatic drive_pin(int k, logic v);
        @(negedge clk);
        pin_in[k] = v;
    endtask

    task automatic settle(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        expect_item("R1 irq0", K_IRQ, 0, 0);
        expect_item("R1 out", K_OUT, 0, 0);
        expect_item("R1 oe0", K_OE, 0, 0);
        rd_expect("R1 status", A_STAT, 0);

        // R2 config byte / output enable
        wr(0, 32'h05);
        rd_expect("R2 readback", 0, 32'h05);
        expect_item("R2 oe0", K_OE, 0, 1);
        expect_item("R2 oe1", K_OE, 1, 0);

        // R3 output levels
        wr(A_OUT, 32'hA5A5_0F0F);
        expect_item("R3 pin_out", K_OUT, 0, 32'hA5A5_0F0F);
        rd_expect("R3 readback", A_OUT, 32'hA5A5_0F0F);

        // R4 input synchronisation latency
        @(negedge clk); bus_addr = AW'(A_IN); pin_in[5] = 1'b1;
        settle(1);
        expect_item("R4 after 1 edge", K_RD, 0, 0);
        settle(1);
        expect_item("R4 after 2 edges", K_RD, 0, 32'h20);

        // R5 rising trigger, latency
        wr(1, 32'h4A);
        drive_pin(1, 1'b1);
        settle(2);
        expect_item("R5 before 3rd edge", K_IRQ, 1, 0);
        settle(1);
        expect_item("R5 after 3rd edge", K_IRQ, 1, 1);

        // R9 sticky, 0 writes ignored, then clear
        settle(20);
        expect_item("R9 still pending", K_IRQ, 1, 1);
        wr(A_STAT, 32'hFFFF_FFFD);
        expect_item("R9 zero write ignored", K_IRQ, 1, 1);
        rd_expect("R9 status word", A_STAT, 32'h2);
        wr(A_STAT, 32'h2);
        expect_item("R9 cleared", K_IRQ, 1, 0);

        // R5 falling edge ignored by rising trigger
        drive_pin(1, 1'b0);
        settle(5);
        expect_item("R5 fall ignored", K_IRQ, 1, 0);

        // R6 falling trigger
        wr(3, 32'h6A);
        drive_pin(3, 1'b1);
        settle(5);
        expect_item("R6 rise ignored", K_IRQ, 3, 0);
        drive_pin(3, 1'b0);
        settle(3);
        expect_item("R6 fall sets", K_IRQ, 3, 1);
        wr(A_STAT, 32'h8);

        // R7 both edges
        wr(2, 32'h8A);
        drive_pin(2, 1'b1);
        settle(3);
        expect_item("R7 rise sets", K_IRQ, 2, 1);
        wr(A_STAT, 32'h4);
        expect_item("R7 cleared", K_IRQ, 2, 0);
        drive_pin(2, 1'b0);
        settle(3);
        expect_item("R7 fall sets", K_IRQ, 2, 1);

        // R10 clear in the same cycle as a new edge: edge wins
        @(negedge clk); pin_in[2] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); bus_we = 1'b1; bus_addr = AW'(A_STAT); bus_wdata = 32'h4;
        @(negedge clk); bus_we = 1'b0;
        expect_item("R10 edge wins", K_IRQ, 2, 1);
        wr(A_STAT, 32'h4);
        expect_item("R10 later clear", K_IRQ, 2, 0);

        // R8 gating: no irq enable, reserved trigger, no input enable
        wr(4, 32'h42);
        wr(6, 32'h0A);
        wr(7, 32'h48);
        drive_pin(4, 1'b1); pin_in[6] = 1'b1; pin_in[7] = 1'b1;
        settle(5);
        rd_expect("R8 no pending", A_STAT, 0);
        expect_item("R8 irq6", K_IRQ, 6, 0);

        // R11 masking keeps the flag
        wr(8, 32'h4A);
        drive_pin(8, 1'b1);
        settle(3);
        expect_item("R11 request", K_IRQ, 8, 1);
        wr(8, 32'h42);
        expect_item("R11 masked", K_IRQ, 8, 0);
        rd_expect("R11 flag kept", A_STAT, 32'h100);
        wr(8, 32'h4A);
        expect_item("R11 unmasked", K_IRQ, 8, 1);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule